// File: doc/BRIEF.md
# Banked Vector Buffer Multiplier

This block is one lane of a sparse matrix times dense vector engine. It keeps one bank's share of the dense input vector in a local memory. It multiplies each sparse-matrix non-zero sent to it by the stored vector entry that the non-zero's column selects. Each product leaves on an output stream tagged with the non-zero's row, so that a later reduction stage can sum the products by row. Upstream routing sends each non-zero to the bank that owns its column, and this block checks that the routing was right.

A mode input splits operation into two phases. In the load phase, vector words arrive on a valid/ready stream and fill the bank from local address zero upward. In the compute phase, non-zeros are taken in and products come out of a fixed-latency pipeline. The whole pipeline stalls under output backpressure. Arithmetic is signed fixed point with a parameterised number of fraction bits.

Top module: `bvm_bank_mult`

## Requirements
- R1: A non-zero is 64 bits: bits 63:32 hold a signed value, bits 31:16 the row and bits 15:0 the column.
- R2: While `mode_compute` is 0, `vec_ready` is 1 and `nz_ready` is 0, so no non-zero is taken in. Each accepted vector word is written at the next local address, and each load phase begins writing at address 0.
- R3: While `mode_compute` is 1, `vec_ready` is 0 and vector words leave the stored entries unchanged.
- R4: The column's low log2(NUM_BANKS) bits name the owning bank. The remaining upper bits give the local address of the entry that is read.
- R5: `out_prod` equals (value × entry) arithmetically shifted right by FRAC bits and kept to its low OUT_W bits. `out_row` equals the non-zero's row.
- R6: A non-zero accepted in cycle c with `out_ready` held high shows up on `out_valid` in cycle c+1+MUL_STAGES and not before.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_prod` and `out_row` hold, and `nz_ready` is 0.
- R8: Every well-addressed non-zero yields exactly one product, in acceptance order, with none dropped or repeated.
- R9: A non-zero whose bank bits differ from BANK_ID is accepted and yields no product, and `err_bank` is 1 from the next cycle.
- R10: A non-zero whose local address is DEPTH or more is handled as in R9.
- R11: `err_bank` stays 1 until reset, and good non-zeros are still processed after it is set.
- R12: After reset, `out_valid` and `err_bank` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_compute | input | 1 | 0 selects load phase, 1 selects compute phase |
| vec_valid | input | 1 | Vector word valid |
| vec_ready | output | 1 | Vector word accepted |
| vec_data | input | VEC_W | Signed fixed-point vector word |
| nz_valid | input | 1 | Non-zero valid |
| nz_ready | output | 1 | Non-zero accepted |
| nz_data | input | 64 | Packed non-zero (value, row, column) |
| out_valid | output | 1 | Product valid |
| out_ready | input | 1 | Downstream can take the product |
| out_row | output | 16 | Row tag of the product |
| out_prod | output | OUT_W | Signed fixed-point product |
| err_bank | output | 1 | Sticky flag for a misrouted or out-of-range non-zero |

## Verification
The bench aims at stalls that land while the pipeline is partly full. If the memory read were not gated by the stall, the held product would change or a product would repeat. It checks that a load phase after compute writes from address zero again; a write pointer that kept running would leave old entries in the low addresses. Misrouted and out-of-range columns are sent between good ones. A design that let them through would emit a stray product, and one that did not keep the flag set would clear `err_bank`. Negative values and negative vector entries check that the shift keeps the sign and that the low bits are taken correctly.

// File: rtl/bvm_pkg.sv
// Package: shared widths and the packed non-zero layout for the bank multiplier.
// Assumes a 64-bit non-zero with a 32-bit value and two 16-bit indexes.
package bvm_pkg;
    localparam int NZ_VAL_W = 32;
    localparam int NZ_IDX_W = 16;
    localparam int NZ_W     = NZ_VAL_W + 2 * NZ_IDX_W;

    // Value in the upper half, then row, then column in the low bits.
    typedef struct packed {
        logic signed [NZ_VAL_W-1:0] value;
        logic [NZ_IDX_W-1:0]        row;
        logic [NZ_IDX_W-1:0]        col;
    } nz_t;
endpackage

// File: rtl/bvm_vec_store.sv
// Module: bank-local vector memory with an in-order write port and a
// synchronous read port that holds its output when rd_en is low.
// Assumes DEPTH >= 2. The write pointer returns to 0 whenever load is off.
module bvm_vec_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic          wr_fire;

    assign wr_ready = load_en;
    assign wr_fire  = wr_valid && load_en;

    // Write pointer: steps per stored word, restarts outside load phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !load_en) begin
            wr_ptr <= '0;
        end else if (wr_fire) begin
            wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Memory write: store the accepted vector word.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Memory read: one cycle latency, output frozen while stalled.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    // R3: no vector word is taken in the compute phase.
    p_no_write_compute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |-> !wr_ready);

    // R2: the first word after entering load lands at address 0.
    p_ptr_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en) |-> (wr_ptr == '0));
endmodule

// File: rtl/bvm_index_check.sv
// Module: splits a column index into owning bank and local address and
// flags columns that do not belong to this bank or exceed its depth.
// Assumes NUM_BANKS is a power of two.
module bvm_index_check #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_ID   = 0,
    parameter int DEPTH     = 256,
    parameter int IDX_W     = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int BSH      = $clog2(NUM_BANKS)
) (
    input  logic [IDX_W-1:0] col,
    output logic [AW-1:0]    local_addr,
    output logic             ok
);
    logic [IDX_W-1:0] upper;
    logic             bank_hit;

    assign upper = col >> BSH;

    generate
        if (NUM_BANKS > 1) begin : g_multi
            // Bank match: low column bits must name this bank.
            assign bank_hit = (int'(col[BSH-1:0]) == BANK_ID);
        end else begin : g_single
            assign bank_hit = 1'b1;
        end
    endgenerate

    // Index decode: local address and validity of the column.
    always_comb begin
        local_addr = upper[AW-1:0];
        ok         = bank_hit && (int'(upper) < DEPTH);
    end
endmodule

// File: rtl/bvm_mul_pipe.sv
// Module: signed fixed-point multiply pipeline of STAGES registers with a
// common advance enable. Stage 0 multiplies and rescales; later stages carry.
// Assumes STAGES >= 1 and FRAC + OUT_W <= VW + EW.
module bvm_mul_pipe #(
    parameter int VW     = 32,
    parameter int EW     = 32,
    parameter int OUT_W  = 32,
    parameter int FRAC   = 16,
    parameter int STAGES = 2,
    parameter int IDX_W  = 16,
    localparam int PW    = VW + EW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    in_valid,
    input  logic signed [VW-1:0]    in_val,
    input  logic signed [EW-1:0]    in_ent,
    input  logic [IDX_W-1:0]        in_row,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_prod,
    output logic [IDX_W-1:0]        out_row
);
    logic signed [PW-1:0]    full;
    logic                    unused_prod;
    logic                    v_q [STAGES];
    logic signed [OUT_W-1:0] p_q [STAGES];
    logic [IDX_W-1:0]        r_q [STAGES];

    assign full        = in_val * in_ent;
    assign unused_prod = ^full;

    // Stage 0: register the rescaled product and its row tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
        end else if (adv) begin
            v_q[0] <= in_valid;
            p_q[0] <= full[FRAC +: OUT_W];
            r_q[0] <= in_row;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Carry stage: move the previous stage forward when advancing.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0;
                end else if (adv) begin
                    v_q[s] <= v_q[s-1];
                    p_q[s] <= p_q[s-1];
                    r_q[s] <= r_q[s-1];
                end
            end
        end
    endgenerate

    assign out_valid = v_q[STAGES-1];
    assign out_prod  = p_q[STAGES-1];
    assign out_row   = r_q[STAGES-1];

    // R6: a valid input to an advancing pipe enters the first stage.
    p_stage_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv && in_valid |=> v_q[0]);

    // R7: a stalled pipe keeps its first stage.
    p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(v_q[0]) && $stable(r_q[0]));
endmodule

// File: rtl/bvm_bank_mult.sv
// Module: top of one banked vector multiplier lane. In load mode it stores
// vector words. In compute mode it reads the entry selected by each
// non-zero's column, multiplies, and emits the product tagged with the row.
// Assumes upstream routing and a power-of-two bank count. Output
// backpressure stalls every stage at once.
module bvm_bank_mult #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_ID    = 0,
    parameter int DEPTH      = 256,
    parameter int VEC_W      = 32,
    parameter int OUT_W      = 32,
    parameter int FRAC       = 16,
    parameter int MUL_STAGES = 2,
    localparam int AW        = $clog2(DEPTH),
    localparam int NZW       = bvm_pkg::NZ_W,
    localparam int IW        = bvm_pkg::NZ_IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_compute,
    input  logic                    vec_valid,
    output logic                    vec_ready,
    input  logic [VEC_W-1:0]        vec_data,
    input  logic                    nz_valid,
    output logic                    nz_ready,
    input  logic [NZW-1:0]          nz_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [IW-1:0]           out_row,
    output logic signed [OUT_W-1:0] out_prod,
    output logic                    err_bank
);
    import bvm_pkg::*;

    nz_t                          nz;
    logic                         adv;
    logic                         accept;
    logic                         addr_ok;
    logic [AW-1:0]                laddr;
    logic [VEC_W-1:0]             entry;
    logic                         s1_valid;
    logic signed [NZ_VAL_W-1:0]   s1_val;
    logic [IW-1:0]                s1_row;

    assign nz       = nz_t'(nz_data);
    assign adv      = !out_valid || out_ready;
    assign nz_ready = mode_compute && adv;
    assign accept   = nz_valid && nz_ready;

    bvm_index_check #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_ID   (BANK_ID),
        .DEPTH     (DEPTH),
        .IDX_W     (IW)
    ) u_idx (
        .col        (nz.col),
        .local_addr (laddr),
        .ok         (addr_ok)
    );

    bvm_vec_store #(
        .DEPTH (DEPTH),
        .DW    (VEC_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (!mode_compute),
        .wr_valid (vec_valid),
        .wr_ready (vec_ready),
        .wr_data  (vec_data),
        .rd_en    (adv),
        .rd_addr  (laddr),
        .rd_data  (entry)
    );

    // Read stage: track value and row alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else if (adv) begin
            s1_valid <= accept && addr_ok;
            s1_val   <= nz.value;
            s1_row   <= nz.row;
        end
    end

    // Error flag: set by any accepted misrouted or out-of-range non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_bank <= 1'b0;
        end else if (accept && !addr_ok) begin
            err_bank <= 1'b1;
        end
    end

    bvm_mul_pipe #(
        .VW     (NZ_VAL_W),
        .EW     (VEC_W),
        .OUT_W  (OUT_W),
        .FRAC   (FRAC),
        .STAGES (MUL_STAGES),
        .IDX_W  (IW)
    ) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .in_valid  (s1_valid),
        .in_val    (s1_val),
        .in_ent    ($signed(entry)),
        .in_row    (s1_row),
        .out_valid (out_valid),
        .out_prod  (out_prod),
        .out_row   (out_row)
    );

    // R2: non-zeros are refused in load mode.
    p_load_blocks_nz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_compute |-> !nz_ready);

    // R7: a stalled output holds its contents.
    p_hold_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_prod) && $stable(out_row));

    // R9: a bad column sets the error flag and starts no product.
    p_bad_sets_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !addr_ok |=> err_bank && !s1_valid);

    // R11: the error flag never clears outside reset.
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_bank |=> err_bank);
endmodule

// File: tb/sim_bvm_bank_mult.sv
`timescale 1ns/1ps
module sim_bvm_bank_mult;
    localparam int NB    = 4;
    localparam int BID   = 1;
    localparam int DEP   = 64;
    localparam int STG   = 2;
    localparam int FR    = 16;
    localparam int NLOAD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_compute = 1'b0;
    logic vec_valid = 1'b0;
    logic vec_ready;
    logic [31:0] vec_data = '0;
    logic nz_valid = 1'b0;
    logic nz_ready;
    logic [63:0] nz_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [15:0] out_row;
    logic signed [31:0] out_prod;
    logic err_bank;

    int total = 0;
    int bad = 0;
    logic signed [31:0] exp_vec [DEP];
    logic [47:0] q [$];
    bit bp_on = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    bvm_bank_mult #(.NUM_BANKS(NB), .BANK_ID(BID), .DEPTH(DEP), .MUL_STAGES(STG), .FRAC(FR)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_compute(mode_compute),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
        .nz_valid(nz_valid), .nz_ready(nz_ready), .nz_data(nz_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_prod(out_prod), .err_bank(err_bank));

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [31:0] prod_of(input logic signed [31:0] v, input logic signed [31:0] e);
        longint p;
        p = longint'(v) * longint'(e);
        p = p >>> FR;
        return p[31:0];
    endfunction

    function automatic bit col_good(input logic [15:0] col);
        return (int'(col % NB) == BID) && (int'(col / NB) < DEP);
    endfunction

    // Monitor: compare each transferred product with the scoreboard head (R5, R8).
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected product", out_prod, 0);
                end else begin
                    logic [47:0] e;
                    e = q.pop_front();
                    chk(out_row == e[47:32], "R5 row tag", out_row, e[47:32]);
                    chk(out_prod == $signed(e[31:0]), "R5 product", out_prod, $signed(e[31:0]));
                end
            end
        end
    end

    // Backpressure: pseudo-random out_ready while enabled (R7, R8).
    always @(negedge clk) begin
        if (bp_on) begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready <= lfsr[0] | lfsr[2];
        end
    end

    // Watchdog.
    initial begin
        #(150000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_words(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic signed [31:0] w;
            w = (i * 37 + seed - 500) * 4096 + i * 3;
            vec_valid = 1'b1;
            vec_data = w;
            #2;
            if (i == 0) chk(vec_ready == 1'b1, "R2 vec_ready in load", vec_ready, 1);
            exp_vec[i] = w;
            @(negedge clk);
        end
        vec_valid = 1'b0;
    endtask

    task automatic send(input logic [15:0] col, input logic [15:0] row, input logic signed [31:0] v);
        bit done = 1'b0;
        nz_data = {v, row, col};
        nz_valid = 1'b1;
        while (!done) begin
            #2;
            if (nz_ready) begin
                done = 1'b1;
                if (col_good(col)) q.push_back({row, prod_of(v, exp_vec[col / NB])});
            end
            @(negedge clk);
        end
        nz_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (STG + 3) @(negedge clk);
        chk(q.size() == 0, "R8 all products delivered", q.size(), 0);
    endtask

    initial begin
        do_reset();
        #1;
        // R12: reset state.
        chk(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
        chk(err_bank == 1'b0, "R12 err_bank after reset", err_bank, 0);
        chk(nz_ready == 1'b0, "R2 nz_ready in load", nz_ready, 0);
        @(negedge clk);

        load_words(NLOAD, 0);

        // R2: non-zeros refused during load.
        nz_data = {32'sd65536, 16'd7, 16'd5};
        nz_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #2;
            chk(nz_ready == 1'b0, "R2 non-zero refused in load", nz_ready, 0);
            @(negedge clk);
        end
        nz_valid = 1'b0;
        repeat (STG + 2) @(negedge clk);
        chk(out_valid == 1'b0, "R2 no product from load-phase non-zero", out_valid, 0);

        mode_compute = 1'b1;
        @(negedge clk);

        // R3: vector words ignored in compute mode.
        vec_valid = 1'b1;
        vec_data = 32'h7FFF_0000;
        #2;
        chk(vec_ready == 1'b0, "R3 vec_ready low in compute", vec_ready, 0);
        repeat (3) @(negedge clk);
        vec_valid = 1'b0;

        // R6: latency of an isolated non-zero (R1 packing, R4 column 3*4+1 -> local 3).
        nz_data = {32'sd98304, 16'd21, 16'(3 * NB + BID)};
        nz_valid = 1'b1;
        #2;
        chk(nz_ready == 1'b1, "R6 accepted when idle", nz_ready, 1);
        q.push_back({16'd21, prod_of(32'sd98304, exp_vec[3])});
        @(negedge clk);
        nz_valid = 1'b0;
        for (int i = 0; i < STG; i++) begin
            #1;
            chk(out_valid == 1'b0, "R6 no early output", out_valid, 0);
            @(negedge clk);
        end
        #1;
        chk(out_valid == 1'b1, "R6 output at latency", out_valid, 1);
        drain();

        // R3: entry 0 still holds the load-phase value.
        send(16'(0 * NB + BID), 16'd2, 32'sd65536);
        // R5: negative values and several addresses.
        send(16'(5 * NB + BID), 16'd100, -32'sd200000);
        send(16'(39 * NB + BID), 16'd65535, 32'sd12345);
        send(16'(17 * NB + BID), 16'd0, -32'sd1);
        drain();

        // R7: stall with a full pipe.
        out_ready = 1'b0;
        send(16'(1 * NB + BID), 16'd11, 32'sd70000);
        send(16'(2 * NB + BID), 16'd12, -32'sd70000);
        send(16'(4 * NB + BID), 16'd13, 32'sd3);
        #1;
        begin
            logic signed [31:0] hp;
            logic [15:0] hr;
            hp = out_prod;
            hr = out_row;
            chk(out_valid == 1'b1, "R7 output waiting", out_valid, 1);
            nz_data = {32'sd5, 16'd14, 16'(6 * NB + BID)};
            nz_valid = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                #2;
                chk(nz_ready == 1'b0, "R7 nz_ready low while stalled", nz_ready, 0);
                chk(out_valid == 1'b1 && out_prod == hp && out_row == hr, "R7 output held", out_prod, hp);
            end
            nz_valid = 1'b0;
        end
        @(negedge clk);
        out_ready = 1'b1;
        drain();

        // R8: burst under random backpressure.
        bp_on = 1'b1;
        for (int i = 0; i < 24; i++) begin
            send(16'(((i * 7) % NLOAD) * NB + BID), 16'(300 + i), 32'(i * 9000 - 100000));
        end
        @(negedge clk);
        bp_on = 1'b0;
        out_ready = 1'b1;
        drain();

        // R10: out-of-range local address.
        chk(err_bank == 1'b0, "R10 flag clear before bad column", err_bank, 0);
        send(16'(DEP * NB + BID), 16'd9, 32'sd65536);
        #1;
        chk(err_bank == 1'b1, "R10 out-of-range sets flag", err_bank, 1);
        repeat (STG + 2) @(negedge clk);
        chk(out_valid == 1'b0, "R10 no product for out-of-range", out_valid, 0);

        do_reset();
        #1;
        chk(err_bank == 1'b0, "R12 flag cleared by reset", err_bank, 0);
        mode_compute = 1'b1;
        @(negedge clk);

        // R9: wrong bank.
        send(16'(2 * NB + ((BID + 1) % NB)), 16'd8, 32'sd65536);
        #1;
        chk(err_bank == 1'b1, "R9 wrong bank sets flag", err_bank, 1);
        repeat (STG + 2) @(negedge clk);
        chk(out_valid == 1'b0, "R9 no product for wrong bank", out_valid, 0);

        // R11: flag sticky, good non-zeros still processed.
        send(16'(8 * NB + BID), 16'd77, 32'sd131072);
        drain();
        chk(err_bank == 1'b1, "R11 flag sticky", err_bank, 1);

        // R2: a new load phase writes from address 0 again.
        mode_compute = 1'b0;
        @(negedge clk);
        load_words(2, 999);
        mode_compute = 1'b1;
        @(negedge clk);
        send(16'(0 * NB + BID), 16'd50, 32'sd65536);
        send(16'(1 * NB + BID), 16'd51, -32'sd65536);
        send(16'(2 * NB + BID), 16'd52, 32'sd65536);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule